// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called side A and side B, and passes data in either direction. Each direction has a capture register. The A-to-B register samples the A bus on the rising edge of its own clock. The B-to-A register samples the B bus on the rising edge of a second, independent clock.

Each outgoing side has its own source select and its own output enable. The source select chooses between live data from the opposite bus and the stored copy in the register for that direction. Neither bus is a tri-state pin. Each bus is modelled as three separate signals: an input vector, an output vector and an output-enable flag. Whatever sits outside the block resolves the bus from these signals.

The two enables have opposite polarities, so one control setting isolates the block and another makes both sides drive. While one side drives live data, the register facing the other way can capture that driven value from its own bus. This lets one bus's data be loaded into both registers. A parameter chooses between an inverting and a non-inverting data path.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The active-low asynchronous reset `rst_n` clears both capture registers to zero. After reset, a side that drives its stored source shows zero, or all ones in the inverting variant.
- R2: On each rising edge of `clk_a2b`, the A-to-B register loads `a_in`. On each rising edge of `clk_b2a`, the B-to-A register loads `b_in`. Between edges, each register holds its value.
- R3: Capture does not depend on the enables. A register loaded while both sides are disabled later shows the loaded value once its side is enabled with the stored source selected.
- R4: `b_oe` equals `en_a2b`, where 1 means enabled. `a_oe` equals the inverse of `en_b2a_n`, where 0 means enabled. With `en_a2b`=0 and `en_b2a_n`=1, both flags are 0 and the block is isolated. A disabled output vector reads all zeros.
- R5: When `b_oe` is 1, `b_out` carries `a_in` if `use_reg_a2b`=0, or the A-to-B register if `use_reg_a2b`=1. Likewise, when `a_oe` is 1, `a_out` carries `b_in` if `use_reg_b2a`=0, or the B-to-A register if `use_reg_b2a`=1.
- R6: With `en_a2b`=1, `en_b2a_n`=0 and both selects at 1, both sides drive their stored contents in the same cycle.
- R7: With `INVERT`=1, every driven output is the bitwise complement of its chosen source. With `INVERT`=0, it is the source unchanged.
- R8: While side B drives live A data, a rising `clk_b2a` stores the driven B value in the B-to-A register, so one bus's data ends up in both registers. The same holds for side A driving live B data and a rising `clk_a2b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_a2b | input | 1 | Capture clock of the A-to-B register |
| clk_b2a | input | 1 | Capture clock of the B-to-A register |
| en_a2b | input | 1 | Side B output enable, active high |
| en_b2a_n | input | 1 | Side A output enable, active low |
| use_reg_a2b | input | 1 | Side B source: 0 live A, 1 stored A-to-B |
| use_reg_b2a | input | 1 | Side A source: 0 live B, 1 stored B-to-A |
| a_in | input | WIDTH | Resolved value of bus A |
| a_out | output | WIDTH | Data driven onto bus A |
| a_oe | output | 1 | Side A is driving |
| b_in | input | WIDTH | Resolved value of bus B |
| b_out | output | WIDTH | Data driven onto bus B |
| b_oe | output | 1 | Side B is driving |

## Verification
The assertions assume that the controls and the bus inputs are steady around each capture-clock edge. They also assume that the two sides never both drive live data at once. If they did, the resolved buses would form a combinational loop through the block, and no stable value would exist.

The bench draws controls and data at random, but rejects any draw that would enable both live paths together. It changes inputs only while both capture clocks are low and raises those clocks only half a period later.

It resolves each bus the way a real bus settles: driven data wins, and otherwise an external source supplies the value. This makes every capture in a store-into-both step see the value that the block itself put on the bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] CLEAR = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CLEAR;
    else        q <= d;
  end

  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(d))) else $error("capture mismatch"); // R2
endmodule

// File: rtl/xcvr_drive_side.sv
module xcvr_drive_side #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             en,
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out,
  output logic             oe
);
  import xcvr_pkg::*;

  src_e             src;
  logic [WIDTH-1:0] chosen;
  logic [WIDTH-1:0] shaped;

  assign src = use_stored ? SRC_STORED : SRC_LIVE;

  always_comb begin
    unique case (src)
      SRC_STORED: chosen = stored;
      default:    chosen = live;
    endcase
  end

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~chosen;
    end else begin : g_pass
      assign shaped = chosen;
    end
  endgenerate

  assign oe  = en;
  assign out = en ? shaped : '0;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rst_n,
  input  logic             clk_a2b,
  input  logic             clk_b2a,
  input  logic             en_a2b,
  input  logic             en_b2a_n,
  input  logic             use_reg_a2b,
  input  logic             use_reg_b2a,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] q_a2b;
  logic [WIDTH-1:0] q_b2a;
  logic             en_a_side;

  assign en_a_side = ~en_b2a_n;

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_a2b (
    .clk(clk_a2b), .rst_n(rst_n), .d(a_in), .q(q_a2b)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_b2a (
    .clk(clk_b2a), .rst_n(rst_n), .d(b_in), .q(q_b2a)
  );

  xcvr_drive_side #(.WIDTH(WIDTH), .INVERT(INVERT)) u_side_b (
    .en(en_a2b), .use_stored(use_reg_a2b), .live(a_in), .stored(q_a2b),
    .out(b_out), .oe(b_oe)
  );

  xcvr_drive_side #(.WIDTH(WIDTH), .INVERT(INVERT)) u_side_a (
    .en(en_a_side), .use_stored(use_reg_b2a), .live(b_in), .stored(q_b2a),
    .out(a_out), .oe(a_oe)
  );

  AST_ISOLATED: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    (!en_a2b && en_b2a_n) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0))
    else $error("isolation broken"); // R4
  AST_B_STORED: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    (en_a2b && use_reg_a2b) |-> (b_out == (q_a2b ^ FLIP)))
    else $error("side B stored path"); // R5
  AST_A_STORED: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    (!en_b2a_n && use_reg_b2a) |-> (a_out == (q_b2a ^ FLIP)))
    else $error("side A stored path"); // R5
  AST_B_LIVE: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    (en_a2b && !use_reg_a2b) |-> (b_out == (a_in ^ FLIP)))
    else $error("side B live path"); // R7
  AST_BOTH_DRIVE: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    (en_a2b && !en_b2a_n) |-> (a_oe && b_oe))
    else $error("dual drive missing"); // R6
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, clk_a2b = 1'b0, clk_b2a = 1'b0;
  logic en_a2b = 1'b0, en_b2a_n = 1'b1, use_reg_a2b = 1'b0, use_reg_b2a = 1'b0;
  logic [W-1:0] ext_a = '0, ext_b = '0;

  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic         a_oe0, b_oe0, a_oe1, b_oe1;
  logic [W-1:0] a_bus0, b_bus0, a_bus1, b_bus1;

  assign a_bus0 = a_oe0 ? a_out0 : ext_a;
  assign b_bus0 = b_oe0 ? b_out0 : ext_b;
  assign a_bus1 = a_oe1 ? a_out1 : ext_a;
  assign b_bus1 = b_oe1 ? b_out1 : ext_b;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u0 (
    .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .en_a2b(en_a2b),
    .en_b2a_n(en_b2a_n), .use_reg_a2b(use_reg_a2b), .use_reg_b2a(use_reg_b2a),
    .a_in(a_bus0), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_bus0), .b_out(b_out0), .b_oe(b_oe0));

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u1 (
    .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .en_a2b(en_a2b),
    .en_b2a_n(en_b2a_n), .use_reg_a2b(use_reg_a2b), .use_reg_b2a(use_reg_b2a),
    .a_in(a_bus1), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_bus1), .b_out(b_out1), .b_oe(b_oe1));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [W-1:0] m_ab [2];
  logic [W-1:0] m_ba [2];

  function automatic logic [W-1:0] pol(input logic [W-1:0] x, input bit inv);
    return inv ? ~x : x;
  endfunction

  // Resolve both buses from the reference registers of variant v.
  function automatic void resolve(input int v, output logic [W-1:0] av,
                                  output logic [W-1:0] bv);
    bit inv = (v == 1);
    bit ad = !en_b2a_n, bd = en_a2b;
    av = ad ? (use_reg_b2a ? pol(m_ba[v], inv) : '0) : ext_a;
    bv = bd ? (use_reg_a2b ? pol(m_ab[v], inv) : '0) : ext_b;
    if (ad && !use_reg_b2a) av = pol(bv, inv);
    if (bd && !use_reg_a2b) bv = pol(av, inv);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // One step: apply controls at negedge, check, then optionally pulse clocks.
  task automatic step(input bit ea, input bit eb_n, input bit sa, input bit sb,
                      input logic [W-1:0] xa, input logic [W-1:0] xb,
                      input bit pa, input bit pb, input string tag);
    logic [W-1:0] av, bv, av1, bv1;
    @(negedge clk);
    clk_a2b = 1'b0; clk_b2a = 1'b0;
    en_a2b = ea; en_b2a_n = eb_n; use_reg_a2b = sa; use_reg_b2a = sb;
    ext_a = xa; ext_b = xb;
    #1;
    resolve(0, av, bv);
    resolve(1, av1, bv1);
    chk("R4", "b_oe", {7'd0, b_oe0}, {7'd0, ea});
    chk("R4", "a_oe", {7'd0, a_oe0}, {7'd0, !eb_n});
    chk(tag, "u0 a_out", a_out0, a_oe0 ? av : '0);
    chk(tag, "u0 b_out", b_out0, b_oe0 ? bv : '0);
    chk("R7", "u1 a_out", a_out1, a_oe1 ? av1 : '0);
    chk("R7", "u1 b_out", b_out1, b_oe1 ? bv1 : '0);
    @(posedge clk);
    if (pa) begin m_ab[0] = av; m_ab[1] = av1; end
    if (pb) begin m_ba[0] = bv; m_ba[1] = bv1; end
    clk_a2b = pa; clk_b2a = pb;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ab[0] = '0; m_ab[1] = '0; m_ba[0] = '0; m_ba[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents visible through both stored paths
    @(negedge clk);
    en_a2b = 1; en_b2a_n = 0; use_reg_a2b = 1; use_reg_b2a = 1; #1;
    chk("R1", "u0 b_out reset", b_out0, '0);
    chk("R1", "u0 a_out reset", a_out0, '0);
    chk("R1", "u1 b_out reset", b_out1, ONES);
    // R3: capture while isolated, then read back
    step(0, 1, 0, 0, 8'h3C, 8'hA5, 1, 1, "R3");
    step(0, 1, 0, 0, 8'h11, 8'h22, 0, 0, "R4");
    step(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R3");
    chk("R3", "u0 b_out stored", b_out0, 8'h3C);
    chk("R3", "u0 a_out stored", a_out0, 8'hA5);
    // R2: capture A only, B register holds
    step(0, 1, 0, 0, 8'h5A, 8'hFF, 1, 0, "R2");
    step(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R2");
    chk("R2", "u0 b_out new", b_out0, 8'h5A);
    chk("R2", "u0 a_out held", a_out0, 8'hA5);
    // R8: B drives live A, clk_b2a stores driven B value
    step(1, 1, 0, 0, 8'hC3, 8'h00, 1, 1, "R8");
    step(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R8");
    chk("R8", "u0 a_out from both", a_out0, 8'hC3);
    chk("R8", "u0 b_out from both", b_out0, 8'hC3);
    // R8: A drives live B, clk_a2b stores driven A value
    step(0, 0, 0, 0, 8'h00, 8'h69, 1, 1, "R8");
    step(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R6");
    chk("R8", "u0 b_out from both", b_out0, 8'h69);
    chk("R6", "u0 a_out dual", a_out0, 8'h69);
    // R5: constrained random sweep
    for (int i = 0; i < 400; i++) begin
      bit ea, ebn, sa, sb;
      ea = 1'($urandom); ebn = 1'($urandom);
      sa = 1'($urandom); sb = 1'($urandom);
      if (ea && !ebn && !sa && !sb) sa = 1'b1;
      step(ea, ebn, sa, sb, 8'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), "R5");
    end
    step(0, 1, 0, 0, 8'h00, 8'h00, 0, 0, "R4");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule